// File: doc/BRIEF.md
# Shared-Buffer Directional Bypass Channel

This block moves flits past a mesh router that has been switched off. It has two bypass lanes that share nothing: lane 0 carries eastbound traffic and lane 1 westbound traffic. Each lane takes flits from two sources, the neighbour upstream in its direction and the local node's injection port. Both sources write into one storage pool that belongs to the lane. Each flit leaves either toward the neighbour downstream or, when its packet is addressed to this column, through the lane's local eject port. Local nodes can therefore send, relay and receive packets with the router fully powered down.

Admission works on whole packets. A head flit enters only if the pool has room for the length written in that head, and from then on its source owns the lane input until the tail has been accepted. When both sources offer a head in the same cycle, ownership alternates between them. Every lane drives an availability flag, which neighbouring routing logic uses to steer traffic away when the lane can no longer take a packet of maximum length.

All ports are valid/ready handshakes with a 32-bit payload and head and tail markers, and they are indexed per lane (bit 0 east, bit 1 west).

Top module: `bypass_pair`

## Requirements
- R1: While reset is active and while no input is valid afterwards, no output is valid, every ready is low, and both availability flags are high.
- R2: The two lanes are independent: stalls, occupancy and traffic on one lane never change the readies, outputs or availability of the other.
- R3: A head flit carries its packet length in bits [10:8]. It is accepted only when the free slots (pool depth minus occupancy at the start of the cycle) are at least that length, so a packet is never split.
- R4: Once a head is accepted, only its source has ready, and that ready stays high until the tail flit has been accepted. Flits of different packets never interleave.
- R5: When both sources present admissible heads in the same cycle, the source that was not granted most recently wins. After reset the injection port is treated as the most recent loser, so it wins the first tie.
- R6: A head flit whose bits [2:0] equal `node_x` leaves on the eject port, and any other head leaves on the downstream port. The body and tail of a packet follow the port its head took, and no flit is valid on both ports at once.
- R7: `avail` of a lane is high exactly when its free slots are at least 6, the longest packet.
- R8: Flits leave a lane in the order they were accepted, with no loss and no duplication. A flit offered but not taken stays valid with unchanged data.
- R9: A flit accepted into an empty lane is valid at that lane's output in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_x | input | 3 | Column coordinate of this node |
| up_valid | input | 2 | Upstream flit valid, per lane |
| up_ready | output | 2 | Upstream flit accepted, per lane |
| up_data | input | 2x32 | Upstream flit payload |
| up_head | input | 2 | Upstream flit is a head |
| up_tail | input | 2 | Upstream flit is a tail |
| inj_valid | input | 2 | Local injection flit valid, per lane |
| inj_ready | output | 2 | Local injection flit accepted |
| inj_data | input | 2x32 | Local injection payload |
| inj_head | input | 2 | Injection flit is a head |
| inj_tail | input | 2 | Injection flit is a tail |
| dn_valid | output | 2 | Downstream flit valid |
| dn_ready | input | 2 | Downstream neighbour takes the flit |
| dn_data | output | 2x32 | Downstream payload |
| dn_head | output | 2 | Downstream flit is a head |
| dn_tail | output | 2 | Downstream flit is a tail |
| ej_valid | output | 2 | Eject flit valid |
| ej_ready | input | 2 | Local node takes the ejected flit |
| ej_data | output | 2x32 | Eject payload |
| ej_head | output | 2 | Ejected flit is a head |
| ej_tail | output | 2 | Ejected flit is a tail |
| avail | output | 2 | Lane can take a maximum-length packet |

## Verification
Most internal state shows up at the ports within one cycle. A wrong occupancy count makes `avail` and the head readies differ from the reference in the same cycle it goes wrong. A lost owner or a wrong round-robin bit changes which ready is raised at the next head, and a wrong stored route sends a body flit to the other port as soon as it reaches the front. Corrupted pool contents or pointers show up as a data or marker mismatch when the affected flit reaches the output, which can be several cycles later if the lane is stalled.

// File: rtl/bpx_pkg.sv
`timescale 1ns/1ps
package bpx_pkg;
  typedef enum logic {SRC_UP = 1'b0, SRC_INJ = 1'b1} bpx_src_e;
  localparam int LANES = 2;
endpackage

// File: rtl/bpx_admit.sv
`timescale 1ns/1ps
// Packet-level admission: space check on heads, ownership until tail,
// round-robin between upstream and local injection.
module bpx_admit
  import bpx_pkg::*;
#(
  parameter int CW    = 5,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  input  logic             up_head,
  input  logic             up_tail,
  input  logic [LEN_W-1:0] up_len,
  input  logic             inj_valid,
  input  logic             inj_head,
  input  logic             inj_tail,
  input  logic [LEN_W-1:0] inj_len,
  input  logic [CW-1:0]    free,
  output logic             up_ready,
  output logic             inj_ready,
  output logic             push,
  output bpx_src_e         sel
);
  logic     busy_q, busy_d;
  bpx_src_e own_q, own_d;
  bpx_src_e last_q, last_d;
  logic     up_ok, inj_ok, grant_any, acc_tail;

  always_comb begin
    up_ok  = rst_n && up_valid  && up_head  && (CW'(up_len)  <= free);
    inj_ok = rst_n && inj_valid && inj_head && (CW'(inj_len) <= free);
    if (busy_q)                sel = own_q;
    else if (up_ok && inj_ok)  sel = (last_q == SRC_UP) ? SRC_INJ : SRC_UP;
    else if (inj_ok)           sel = SRC_INJ;
    else                       sel = SRC_UP;
    grant_any = rst_n && (busy_q || up_ok || inj_ok);
    up_ready  = grant_any && (sel == SRC_UP);
    inj_ready = grant_any && (sel == SRC_INJ);
    push      = (sel == SRC_INJ) ? (inj_valid && inj_ready) : (up_valid && up_ready);
    acc_tail  = (sel == SRC_INJ) ? inj_tail : up_tail;
    busy_d = busy_q;
    own_d  = own_q;
    last_d = last_q;
    if (push) begin
      busy_d = !acc_tail;
      if (!busy_q) begin
        own_d  = sel;
        last_d = sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= SRC_UP;
      last_q <= SRC_UP;
    end else begin
      busy_q <= busy_d;
      own_q  <= own_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/bpx_pool.sv
`timescale 1ns/1ps
// Common flit store of one lane, filled in admission order.
module bpx_pool #(
  parameter int W     = 34,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] occ
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] occ_q, occ_d;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? step_ptr(wr_q) : wr_q;
    rd_d  = pop  ? step_ptr(rd_q) : rd_q;
    occ_d = occ_q;
    if (push && !pop)      occ_d = occ_q + 1'b1;
    else if (pop && !push) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      occ_q <= occ_d;
    end
  end

  assign rdata = mem[rd_q];
  assign occ   = occ_q;
endmodule

// File: rtl/bpx_steer.sv
`timescale 1ns/1ps
// Chooses downstream or eject for the front flit; body follows its head.
module bpx_steer #(
  parameter int XW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] node_x,
  input  logic          f_valid,
  input  logic          f_head,
  input  logic [XW-1:0] f_dest,
  input  logic          dn_ready,
  input  logic          ej_ready,
  output logic          dn_valid,
  output logic          ej_valid,
  output logic          pop
);
  logic route_q, route_d, to_ej;

  always_comb begin
    to_ej    = f_head ? (f_dest == node_x) : route_q;
    dn_valid = f_valid && !to_ej;
    ej_valid = f_valid && to_ej;
    pop      = (dn_valid && dn_ready) || (ej_valid && ej_ready);
    route_d  = (pop && f_head) ? to_ej : route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= 1'b0;
    else        route_q <= route_d;
  end
endmodule

// File: rtl/bpx_lane.sv
`timescale 1ns/1ps
// One direction: admission, shared pool, output steering.
module bpx_lane
  import bpx_pkg::*;
#(
  parameter int FLIT_W  = 32,
  parameter int DEPTH   = 16,
  parameter int XW      = 3,
  parameter int LEN_LSB = 8,
  parameter int LEN_W   = 3,
  parameter int MAX_PKT = 6,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int W      = FLIT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XW-1:0]     node_x,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [FLIT_W-1:0] up_data,
  input  logic              up_head,
  input  logic              up_tail,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [FLIT_W-1:0] inj_data,
  input  logic              inj_head,
  input  logic              inj_tail,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [FLIT_W-1:0] dn_data,
  output logic              dn_head,
  output logic              dn_tail,
  output logic              ej_valid,
  input  logic              ej_ready,
  output logic [FLIT_W-1:0] ej_data,
  output logic              ej_head,
  output logic              ej_tail,
  output logic              avail,
  output logic [CW-1:0]     occ
);
  logic [CW-1:0]     free;
  logic              push, pop;
  bpx_src_e          sel;
  logic [W-1:0]      wdata, rdata;
  logic              f_head, f_tail;
  logic [FLIT_W-1:0] f_data;

  assign free  = CW'(DEPTH) - occ;
  assign avail = (free >= CW'(MAX_PKT));
  assign wdata = (sel == SRC_INJ) ? {inj_head, inj_tail, inj_data}
                                  : {up_head, up_tail, up_data};
  assign {f_head, f_tail, f_data} = rdata;

  bpx_admit #(.CW(CW), .LEN_W(LEN_W)) u_admit (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_head(up_head), .up_tail(up_tail),
    .up_len(up_data[LEN_LSB +: LEN_W]),
    .inj_valid(inj_valid), .inj_head(inj_head), .inj_tail(inj_tail),
    .inj_len(inj_data[LEN_LSB +: LEN_W]),
    .free(free), .up_ready(up_ready), .inj_ready(inj_ready),
    .push(push), .sel(sel)
  );

  bpx_pool #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_pool (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(wdata),
    .pop(pop), .rdata(rdata), .occ(occ)
  );

  bpx_steer #(.XW(XW)) u_steer (
    .clk(clk), .rst_n(rst_n), .node_x(node_x),
    .f_valid(occ != '0), .f_head(f_head), .f_dest(f_data[XW-1:0]),
    .dn_ready(dn_ready), .ej_ready(ej_ready),
    .dn_valid(dn_valid), .ej_valid(ej_valid), .pop(pop)
  );

  assign dn_data = f_data;
  assign dn_head = f_head;
  assign dn_tail = f_tail;
  assign ej_data = f_data;
  assign ej_head = f_head;
  assign ej_tail = f_tail;
endmodule

// File: rtl/bypass_pair.sv
`timescale 1ns/1ps
// Eastbound (index 0) and westbound (index 1) bypass lanes.
module bypass_pair
  import bpx_pkg::*;
#(
  parameter int FLIT_W  = 32,
  parameter int DEPTH   = 16,
  parameter int XW      = 3,
  parameter int LEN_LSB = 8,
  parameter int LEN_W   = 3,
  parameter int MAX_PKT = 6,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [XW-1:0]                node_x,
  input  logic [LANES-1:0]             up_valid,
  output logic [LANES-1:0]             up_ready,
  input  logic [LANES-1:0][FLIT_W-1:0] up_data,
  input  logic [LANES-1:0]             up_head,
  input  logic [LANES-1:0]             up_tail,
  input  logic [LANES-1:0]             inj_valid,
  output logic [LANES-1:0]             inj_ready,
  input  logic [LANES-1:0][FLIT_W-1:0] inj_data,
  input  logic [LANES-1:0]             inj_head,
  input  logic [LANES-1:0]             inj_tail,
  output logic [LANES-1:0]             dn_valid,
  input  logic [LANES-1:0]             dn_ready,
  output logic [LANES-1:0][FLIT_W-1:0] dn_data,
  output logic [LANES-1:0]             dn_head,
  output logic [LANES-1:0]             dn_tail,
  output logic [LANES-1:0]             ej_valid,
  input  logic [LANES-1:0]             ej_ready,
  output logic [LANES-1:0][FLIT_W-1:0] ej_data,
  output logic [LANES-1:0]             ej_head,
  output logic [LANES-1:0]             ej_tail,
  output logic [LANES-1:0]             avail
);
  logic [1:0]                   rst_q;
  logic                         rst_i;
  logic [LANES-1:0][CW-1:0]     lane_occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bpx_lane #(
      .FLIT_W(FLIT_W), .DEPTH(DEPTH), .XW(XW),
      .LEN_LSB(LEN_LSB), .LEN_W(LEN_W), .MAX_PKT(MAX_PKT)
    ) u_lane (
      .clk(clk), .rst_n(rst_i), .node_x(node_x),
      .up_valid(up_valid[l]), .up_ready(up_ready[l]), .up_data(up_data[l]),
      .up_head(up_head[l]), .up_tail(up_tail[l]),
      .inj_valid(inj_valid[l]), .inj_ready(inj_ready[l]), .inj_data(inj_data[l]),
      .inj_head(inj_head[l]), .inj_tail(inj_tail[l]),
      .dn_valid(dn_valid[l]), .dn_ready(dn_ready[l]), .dn_data(dn_data[l]),
      .dn_head(dn_head[l]), .dn_tail(dn_tail[l]),
      .ej_valid(ej_valid[l]), .ej_ready(ej_ready[l]), .ej_data(ej_data[l]),
      .ej_head(ej_head[l]), .ej_tail(ej_tail[l]),
      .avail(avail[l]), .occ(lane_occ[l])
    );
  end
endmodule

// File: rtl/bpx_check.sv
`timescale 1ns/1ps
module bpx_check #(
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 16,
  parameter int CW     = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            up_valid,
  input logic [1:0]            up_ready,
  input logic [1:0]            up_tail,
  input logic [1:0]            inj_valid,
  input logic [1:0]            inj_ready,
  input logic [1:0]            inj_tail,
  input logic [1:0]            dn_valid,
  input logic [1:0]            dn_ready,
  input logic [1:0][FLIT_W-1:0] dn_data,
  input logic [1:0]            ej_valid,
  input logic [1:0]            ej_ready,
  input logic [1:0][FLIT_W-1:0] ej_data,
  input logic [1:0][CW-1:0]    lane_occ
);
  for (genvar l = 0; l < 2; l++) begin : g_chk
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      lane_occ[l] <= CW'(DEPTH));
    a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      !(up_ready[l] && inj_ready[l]));
    a_r4_up_held: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid[l] && up_ready[l] && !up_tail[l]) |=> up_ready[l]);
    a_r4_inj_held: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_valid[l] && inj_ready[l] && !inj_tail[l]) |=> inj_ready[l]);
    a_r6_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      !(dn_valid[l] && ej_valid[l]));
    a_r8_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid[l] && !dn_ready[l]) |=> (dn_valid[l] && $stable(dn_data[l])));
    a_r8_ej_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ej_valid[l] && !ej_ready[l]) |=> (ej_valid[l] && $stable(ej_data[l])));
  end
endmodule

bind bypass_pair bpx_check #(.FLIT_W(FLIT_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .up_valid(up_valid), .up_ready(up_ready), .up_tail(up_tail),
  .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_tail(inj_tail),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
  .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_data(ej_data),
  .lane_occ(lane_occ)
);

// File: tb/sim_bypass_pair.sv
`timescale 1ns/1ps
module sim_bypass_pair;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]       node_x;
  logic [1:0]       up_valid, up_ready, up_head, up_tail;
  logic [1:0][31:0] up_data;
  logic [1:0]       inj_valid, inj_ready, inj_head, inj_tail;
  logic [1:0][31:0] inj_data;
  logic [1:0]       dn_valid, dn_ready, dn_head, dn_tail;
  logic [1:0][31:0] dn_data;
  logic [1:0]       ej_valid, ej_ready, ej_head, ej_tail;
  logic [1:0][31:0] ej_data;
  logic [1:0]       avail;

  bypass_pair u0 (
    .clk(clk), .rst_n(rst_n), .node_x(node_x),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .up_head(up_head), .up_tail(up_tail),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_data(inj_data),
    .inj_head(inj_head), .inj_tail(inj_tail),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .dn_head(dn_head), .dn_tail(dn_tail),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_data(ej_data),
    .ej_head(ej_head), .ej_tail(ej_tail), .avail(avail)
  );

  int total = 0;
  int bad = 0;

  // stimulus queues, index lane*2+src (src 0 upstream, 1 injection)
  logic [33:0] sq[4][$];
  bit          pres[4];
  // reference model per lane
  logic [33:0] mq[2][$];
  bit          m_busy[2];
  int          m_own[2];
  int          m_last[2];
  bit          m_route[2];
  int          rdy_dn[2], rdy_ej[2];
  int          gap;
  int          dn_cnt[2], ej_cnt[2];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add_pkt(int l, int s, int dx, int len);
    for (int i = 0; i < len; i++) begin
      logic [33:0] f;
      f[31:0] = $urandom;
      if (i == 0) begin
        f[2:0]  = 3'(dx);
        f[10:8] = 3'(len);
      end
      f[33] = (i == 0);
      f[32] = (i == len - 1);
      sq[l*2+s].push_back(f);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // one clock cycle, entered and left at a falling edge
  task automatic step();
    for (int k = 0; k < 4; k++)
      if (!pres[k] && sq[k].size() > 0 && ($urandom % 100) >= gap) pres[k] = 1'b1;
    for (int l = 0; l < 2; l++) begin
      logic [33:0] fu, fi;
      fu = pres[l*2]   ? sq[l*2][0]   : 34'h0;
      fi = pres[l*2+1] ? sq[l*2+1][0] : 34'h0;
      up_valid[l]  = pres[l*2];
      {up_head[l], up_tail[l], up_data[l]} = fu;
      inj_valid[l] = pres[l*2+1];
      {inj_head[l], inj_tail[l], inj_data[l]} = fi;
      dn_ready[l] = (($urandom % 100) < rdy_dn[l]);
      ej_ready[l] = (($urandom % 100) < rdy_ej[l]);
    end
    #1;
    for (int l = 0; l < 2; l++) begin
      int sz, fr, lu, li, sel, k;
      logic [33:0] fh, f;
      bit to_ej, e_dn, e_ej, ok_u, ok_i;
      sz = mq[l].size();
      fr = DEPTH - sz;
      fh = (sz > 0) ? mq[l][0] : 34'h0;
      to_ej = fh[33] ? (fh[2:0] == node_x) : m_route[l];
      e_dn = (sz > 0) && !to_ej;
      e_ej = (sz > 0) && to_ej;
      lu = int'(up_data[l][10:8]);
      li = int'(inj_data[l][10:8]);
      ok_u = up_valid[l] && up_head[l] && (lu <= fr);
      ok_i = inj_valid[l] && inj_head[l] && (li <= fr);
      if (m_busy[l])         sel = m_own[l];
      else if (ok_u && ok_i) sel = (m_last[l] == 0) ? 1 : 0;
      else if (ok_i)         sel = 1;
      else if (ok_u)         sel = 0;
      else                   sel = -1;
      chk($sformatf("R6/R9 lane%0d dn_valid", l), 64'(dn_valid[l]), 64'(e_dn));
      chk($sformatf("R6/R9 lane%0d ej_valid", l), 64'(ej_valid[l]), 64'(e_ej));
      chk($sformatf("R5 lane%0d up_ready (R3 R4)", l), 64'(up_ready[l]), 64'(sel == 0));
      chk($sformatf("R5 lane%0d inj_ready (R3 R4)", l), 64'(inj_ready[l]), 64'(sel == 1));
      chk($sformatf("R7 lane%0d avail", l), 64'(avail[l]), 64'(fr >= 6));
      if (e_dn) chk($sformatf("R8 lane%0d dn flit", l),
                    {30'h0, dn_head[l], dn_tail[l], dn_data[l]}, 64'(fh));
      if (e_ej) chk($sformatf("R8 lane%0d ej flit", l),
                    {30'h0, ej_head[l], ej_tail[l], ej_data[l]}, 64'(fh));
      if ((e_dn && dn_ready[l]) || (e_ej && ej_ready[l])) begin
        if (fh[33]) m_route[l] = to_ej;
        void'(mq[l].pop_front());
        if (e_dn) dn_cnt[l]++; else ej_cnt[l]++;
      end
      if (sel >= 0) begin
        k = l*2 + sel;
        if (pres[k]) begin
          f = sq[k][0];
          mq[l].push_back(f);
          if (f[33] && !m_busy[l]) begin
            m_busy[l] = 1'b1;
            m_own[l]  = sel;
            m_last[l] = sel;
          end
          if (f[32]) m_busy[l] = 1'b0;
          void'(sq[k].pop_front());
          pres[k] = 1'b0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic bit all_empty();
    return sq[0].size() == 0 && sq[1].size() == 0 && sq[2].size() == 0 &&
           sq[3].size() == 0 && mq[0].size() == 0 && mq[1].size() == 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R8 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int c0, c1;
    node_x = 3'd3;
    up_valid = '0; up_data = '0; up_head = '0; up_tail = '0;
    inj_valid = '0; inj_data = '0; inj_head = '0; inj_tail = '0;
    dn_ready = '0; ej_ready = '0;
    gap = 0;
    for (int l = 0; l < 2; l++) begin
      m_busy[l] = 0; m_own[l] = 0; m_last[l] = 0; m_route[l] = 0;
      rdy_dn[l] = 100; rdy_ej[l] = 100; dn_cnt[l] = 0; ej_cnt[l] = 0;
    end
    for (int k = 0; k < 4; k++) pres[k] = 0;
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    #1;
    chk("R1 valid in reset", 64'({dn_valid, ej_valid}), 64'h0);
    chk("R1 avail in reset", 64'(avail), 64'h3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 valid after reset", 64'({dn_valid, ej_valid}), 64'h0);
    chk("R1 ready after reset", 64'({up_ready, inj_ready}), 64'h0);
    chk("R1 avail after reset", 64'(avail), 64'h3);
    @(negedge clk);

    // R5: first tie on lane 1 goes to injection, next tie to upstream
    add_pkt(1, 0, 6, 2);
    add_pkt(1, 1, 6, 2);
    add_pkt(1, 0, 6, 2);
    add_pkt(1, 1, 6, 2);
    step();
    chk("R5 first tie injection flits left", 64'(sq[3].size()), 64'd3);
    chk("R5 first tie upstream untouched", 64'(sq[2].size()), 64'd4);
    step();
    step();
    chk("R5 second tie upstream won", 64'(sq[2].size()), 64'd3);
    chk("R4 injection held off", 64'(sq[3].size()), 64'd2);
    run(20);

    // R6: local delivery versus pass-through on lane 0
    c0 = ej_cnt[0]; c1 = dn_cnt[0];
    add_pkt(0, 1, 3, 3);
    add_pkt(0, 0, 6, 2);
    run(20);
    chk("R6 ejected flits", 64'(ej_cnt[0] - c0), 64'd3);
    chk("R6 forwarded flits", 64'(dn_cnt[0] - c1), 64'd2);

    // R3/R7: fill lane 0 with outputs blocked
    rdy_dn[0] = 0; rdy_ej[0] = 0;
    for (int i = 0; i < 4; i++) add_pkt(0, 0, 5, 6);
    run(30);
    chk("R7 lane0 avail low when 4 free", 64'(avail[0]), 64'h0);
    chk("R2 lane1 avail unaffected", 64'(avail[1]), 64'h1);
    chk("R3 head of 6 refused with 4 free", 64'(up_ready[0]), 64'h0);
    add_pkt(0, 1, 3, 2);
    run(10);
    chk("R3 2-flit packet fits in 4 free", 64'(sq[1].size()), 64'd0);
    rdy_dn[0] = 100; rdy_ej[0] = 100;
    run(60);

    // R2: lane 1 stalled, lane 0 keeps moving
    rdy_dn[1] = 0; rdy_ej[1] = 0;
    for (int i = 0; i < 3; i++) add_pkt(1, i % 2, i + 2, 4);
    run(20);
    c0 = dn_cnt[0] + ej_cnt[0];
    c1 = dn_cnt[1] + ej_cnt[1];
    for (int i = 0; i < 4; i++) add_pkt(0, i % 2, (i * 3) % 8, 2 + i);
    run(60);
    chk("R2 lane0 delivered while lane1 stalled", 64'((dn_cnt[0] + ej_cnt[0] - c0) == 14), 64'h1);
    chk("R2 lane1 stayed stalled", 64'(dn_cnt[1] + ej_cnt[1] - c1), 64'h0);
    rdy_dn[1] = 100; rdy_ej[1] = 100;

    // mixed traffic with back-pressure and gaps
    gap = 30;
    for (int r = 0; r < 6; r++) begin
      rdy_dn[0] = 40 + r * 10; rdy_ej[0] = 90 - r * 10;
      rdy_dn[1] = 70; rdy_ej[1] = 30 + r * 10;
      for (int i = 0; i < 12; i++)
        add_pkt(i % 2, (i / 2) % 2, $urandom % 8, 2 + ($urandom % 5));
      run(250);
    end

    // drain
    gap = 0;
    for (int l = 0; l < 2; l++) begin rdy_dn[l] = 100; rdy_ej[l] = 100; end
    for (int i = 0; i < 2000 && !all_empty(); i++) step();
    chk("R8 every accepted flit delivered", 64'(all_empty()), 64'h1);
    run(2);
    chk("R7 avail after drain", 64'(avail), 64'h3);
    summary();
    $finish;
  end
endmodule